// File: doc/BRIEF.md
# Cache-Line Aligned Read Burst Terminator

This block decides, one dword at a time, where a transmit-side DMA read burst should end. The goal is that the next burst starts on a cache-line-aligned address. It watches the dword address of each transfer, the transmit FIFO's almost-full flag and an arbitration byte counter. It then raises a terminate request on the dword where the burst should stop. If the stop is made to hand the bus to another pending DMA channel, it also raises a switch strobe on that same dword.

Alignment is active only when the align-enable input is set and the line size is 8 or 16 dwords. While alignment is active, an early stop is held back until the last dword of a cache line. When a control-structure read is requested, the block also moves its start address down to the first dword of the line.

When alignment is inactive, early stops happen on the dword where the condition is seen, and the start address passes through unchanged. Bus protocol timing, FIFO storage and descriptor parsing belong to the surrounding logic.

Top module: `rd_burst_align`

## Requirements
- R1: Alignment is active only when `alignEn` is 1 and `lineSizeDw` is 8 or 16. When it is inactive, `startAddr` equals `reqAddr`.
- R2: Any `lineSizeDw` value other than 8 or 16 makes the block behave as if `alignEn` were 0, even when `alignEn` is 1.
- R3: While alignment is active, an almost-full indication seen during a burst causes `termReq` on the next dword whose address has all low log2(line size) bits set to one. That dword may be the current one. The indication is remembered even if `fifoAlmostFull` drops before that dword.
- R4: While alignment is inactive, `fifoAlmostFull` on a transferred dword raises `termReq` on that same dword.
- R5: `lastDw` with `dwValid` raises `termReq` on that dword. No extra dwords are requested when a burst runs out of length before a line end.
- R6: The arbitration counter adds 4 bytes per transferred dword and restarts from zero when `burstStart` is 1. The limit counts as reached when the count, including the current dword, is at least `arbLimit`. Once reached, it stays reached for the rest of the burst, because the count saturates at `arbLimit`.
- R7: While alignment is active, with `arbEn` 1, the limit reached and `otherPending` 1, `switchReq` and `termReq` are both raised only on a line-final dword. When `arbEn` is 0, the counter never causes a switch.
- R8: While alignment is inactive, with `arbEn` 1, the limit reached and `otherPending` 1, `switchReq` and `termReq` are raised on that same dword.
- R9: While alignment is active and `ctrlRead` is 1, `startAddr` is `reqAddr` with its low log2(line size) bits cleared.
- R10: `termReq` and `switchReq` are 0 whenever `dwValid` is 0, including right after reset. A terminated burst leaves no remembered pressure or count behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alignEn | input | 1 | Read-align enable configuration bit |
| lineSizeDw | input | LSZ_W | Cache line size in dwords |
| burstStart | input | 1 | Marks the first dword of a burst (together with `dwValid`) |
| dwValid | input | 1 | A dword is transferred this cycle |
| dwAddr | input | ADDR_W | Dword address of the current transfer |
| lastDw | input | 1 | The burst's length ends on this dword |
| fifoAlmostFull | input | 1 | Transmit FIFO almost full |
| arbEn | input | 1 | Arbitration byte limit enabled |
| arbLimit | input | CNT_W | Arbitration byte limit |
| otherPending | input | 1 | Another DMA channel is waiting |
| ctrlRead | input | 1 | The requested read is a control-structure read |
| reqAddr | input | ADDR_W | Requested start dword address |
| startAddr | output | ADDR_W | Adjusted start dword address |
| termReq | output | 1 | End the burst on this dword |
| switchReq | output | 1 | Hand over to the pending channel after this dword |

## Verification
On every cycle, the assertions check the following:
- An early stop while alignment is active lands only on a line-final dword.
- A switch never happens without a stop.
- Idle cycles stay quiet.
- The saturating counter never exceeds the limit, and a stop clears all remembered state.
- An aligned control read always yields a line-aligned start address.

The bench's scenarios are needed to show the remaining properties:
- A dropped almost-full flag still forces the stop at the correct later dword.
- The limit is reached on exactly the right dword.
- An unsupported line size falls back to immediate stops.
- A short burst ends without padding.

// File: rtl/burst_align_pkg.sv
package burst_align_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic advance;   // dword moved, burst continues
    logic clear;     // burst ends on this dword
  } dpCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic active;     // alignment in force
    logic atLineEnd;  // current dword is last of its line
    logic pressure;   // almost-full seen in this burst
    logic limitHit;   // arbitration byte limit reached
  } dpStat_t;

  localparam int unsigned SMALL_LINE = 8;
  localparam int unsigned LARGE_LINE = 16;
endpackage

// File: rtl/ba_datapath.sv
module ba_datapath
  import burst_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int LSZ_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alignEn,
  input  logic [LSZ_W-1:0]  lineSizeDw,
  input  logic              burstStart,
  input  logic [ADDR_W-1:0] dwAddr,
  input  logic              fifoAlmostFull,
  input  logic              arbEn,
  input  logic [CNT_W-1:0]  arbLimit,
  input  logic              ctrlRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] startAddr
);
  localparam logic [CNT_W:0] DW_BYTES = (CNT_W+1)'(4);

  logic              isSmall, isLarge, sizeOk, active;
  logic [ADDR_W-1:0] lowMask;
  logic [CNT_W-1:0]  cntQ, cntBase, cntNext;
  logic [CNT_W:0]    cntSum;
  logic              pendQ, pendBase, pressure, limitHit;

  assign isSmall = (lineSizeDw == LSZ_W'(SMALL_LINE));
  assign isLarge = (lineSizeDw == LSZ_W'(LARGE_LINE));
  assign sizeOk  = isSmall | isLarge;
  assign active  = alignEn & sizeOk;
  assign lowMask = isLarge ? ADDR_W'(LARGE_LINE - 1) : ADDR_W'(SMALL_LINE - 1);

  // saturating byte counter, restarted by the burst's first dword
  assign cntBase  = burstStart ? '0 : cntQ;
  assign cntSum   = {1'b0, cntBase} + DW_BYTES;
  assign limitHit = arbEn & (cntSum >= {1'b0, arbLimit});
  assign cntNext  = (cntSum >= {1'b0, arbLimit}) ? arbLimit : cntSum[CNT_W-1:0];

  // remembered resource pressure
  assign pendBase = burstStart ? 1'b0 : pendQ;
  assign pressure = fifoAlmostFull | pendBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      pendQ <= 1'b0;
    end else if (ctl.clear) begin
      cntQ  <= '0;
      pendQ <= 1'b0;
    end else if (ctl.advance) begin
      cntQ  <= cntNext;
      pendQ <= pressure;
    end
  end

  assign stat.active    = active;
  assign stat.atLineEnd = active & ((dwAddr & lowMask) == lowMask);
  assign stat.pressure  = pressure;
  assign stat.limitHit  = limitHit;

  assign startAddr = (active & ctrlRead) ? (reqAddr & ~lowMask) : reqAddr;

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (cntQ <= $past(arbLimit)));

  p_clear_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (cntQ == '0) && !pendQ);
endmodule

// File: rtl/ba_control.sv
module ba_control
  import burst_align_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dwValid,
  input  logic    lastDw,
  input  logic    otherPending,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    termReq,
  output logic    switchReq
);
  logic allowPt, arbWant, earlyStop;

  // stops other than length end are deferred to a line end when aligned
  assign allowPt   = ~stat.active | stat.atLineEnd;
  assign arbWant   = stat.limitHit & otherPending;
  assign earlyStop = (stat.pressure | arbWant) & allowPt;

  assign termReq   = dwValid & (lastDw | earlyStop);
  assign switchReq = dwValid & arbWant & allowPt;

  assign ctl.clear   = termReq;
  assign ctl.advance = dwValid & ~termReq;

  p_early_line_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (termReq && !lastDw && stat.active) |-> stat.atLineEnd);

  p_switch_with_term_r7: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |-> termReq);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dwValid |-> (!termReq && !switchReq));

  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clear && ctl.advance));
endmodule

// File: rtl/rd_burst_align.sv
module rd_burst_align
  import burst_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  parameter int LSZ_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alignEn,
  input  logic [LSZ_W-1:0]  lineSizeDw,
  input  logic              burstStart,
  input  logic              dwValid,
  input  logic [ADDR_W-1:0] dwAddr,
  input  logic              lastDw,
  input  logic              fifoAlmostFull,
  input  logic              arbEn,
  input  logic [CNT_W-1:0]  arbLimit,
  input  logic              otherPending,
  input  logic              ctrlRead,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] startAddr,
  output logic              termReq,
  output logic              switchReq
);
  dpCtrl_t ctl;
  dpStat_t stat;

  ba_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LSZ_W(LSZ_W)) u_dp (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .lineSizeDw(lineSizeDw),
    .burstStart(burstStart), .dwAddr(dwAddr), .fifoAlmostFull(fifoAlmostFull),
    .arbEn(arbEn), .arbLimit(arbLimit), .ctrlRead(ctrlRead), .reqAddr(reqAddr),
    .ctl(ctl), .stat(stat), .startAddr(startAddr)
  );

  ba_control u_ctl (
    .clk(clk), .rstN(rstN), .dwValid(dwValid), .lastDw(lastDw),
    .otherPending(otherPending), .stat(stat), .ctl(ctl),
    .termReq(termReq), .switchReq(switchReq)
  );

  logic sizeGood;
  assign sizeGood = (lineSizeDw == LSZ_W'(SMALL_LINE)) || (lineSizeDw == LSZ_W'(LARGE_LINE));

  p_ctrl_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    (alignEn && sizeGood && ctrlRead) |->
      ((startAddr & ADDR_W'(lineSizeDw - LSZ_W'(1))) == '0));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(alignEn && sizeGood) |-> (startAddr == reqAddr));
endmodule

// File: tb/tb_rd_burst_align.sv
module tb_rd_burst_align;
  logic        clk = 1'b0;
  logic        rstN;
  logic        alignEn, burstStart, dwValid, lastDw, fifoAlmostFull;
  logic        arbEn, otherPending, ctrlRead;
  logic [7:0]  lineSizeDw;
  logic [31:0] dwAddr, reqAddr, startAddr;
  logic [11:0] arbLimit;
  logic        termReq, switchReq;

  always #10 clk = ~clk;   // 50 MHz

  rd_burst_align dut (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .lineSizeDw(lineSizeDw),
    .burstStart(burstStart), .dwValid(dwValid), .dwAddr(dwAddr), .lastDw(lastDw),
    .fifoAlmostFull(fifoAlmostFull), .arbEn(arbEn), .arbLimit(arbLimit),
    .otherPending(otherPending), .ctrlRead(ctrlRead), .reqAddr(reqAddr),
    .startAddr(startAddr), .termReq(termReq), .switchReq(switchReq)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;
  // reference model state
  int  mCnt = 0;
  bit  mPend = 0;
  bit  expTerm, expSw;
  int  expStart;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // inputs already driven; compare, advance model, wait for next drive point
  task automatic step(input string tag);
    bit act, lineEnd, pend, hit, allow;
    int base, ls, a;
    #1;
    ls = int'(lineSizeDw);
    a  = int'(dwAddr);
    act     = alignEn && (ls == 8 || ls == 16);
    lineEnd = act && ((a % ls) == ls - 1);
    base    = burstStart ? 0 : mCnt;
    pend    = fifoAlmostFull || (!burstStart && mPend);
    hit     = arbEn && (base + 4 >= int'(arbLimit));
    allow   = !act || lineEnd;
    expSw   = dwValid && hit && otherPending && allow;
    expTerm = dwValid && (lastDw || ((pend || (hit && otherPending)) && allow));
    expStart = (act && ctrlRead) ? int'(reqAddr) - (int'(reqAddr) % ls) : int'(reqAddr);
    chk(tag, "termReq", termReq, expTerm);
    chk(tag, "switchReq", switchReq, expSw);
    chk(tag, "startAddr", startAddr, expStart);
    if (dwValid) begin
      if (expTerm) begin mCnt = 0; mPend = 0; end
      else begin
        mCnt  = (base + 4 >= int'(arbLimit)) ? int'(arbLimit) : base + 4;
        mPend = pend;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    dwValid = 0; burstStart = 0; lastDw = 0; fifoAlmostFull = 0;
    step(tag);
  endtask

  // runs one burst; returns the index of the dword that ended it
  task automatic runBurst(input int a0, input int len, input int faIdx,
                          input int opIdx, input string tag, output int endIdx);
    endIdx = -1;
    for (int i = 0; i < len; i++) begin
      dwValid = 1; burstStart = (i == 0); dwAddr = 32'(a0 + i);
      lastDw = (i == len - 1); fifoAlmostFull = (i == faIdx);
      otherPending = (opIdx >= 0) && (i >= opIdx);
      step(tag);
      if (expTerm) begin endIdx = i; break; end
    end
    otherPending = 0;
    idle(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int e;
    rstN = 0; alignEn = 1; lineSizeDw = 8; burstStart = 0; dwValid = 0;
    dwAddr = 0; lastDw = 0; fifoAlmostFull = 0; arbEn = 0; arbLimit = 64;
    otherPending = 0; ctrlRead = 0; reqAddr = 32'h25;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: quiet after reset
    idle("R10");

    // R5: short burst ends at its length, no padding
    runBurst(0, 5, -1, -1, "R5", e);
    chk("R5", "end index", e, 4);

    // R3: pulse at addr 3 (line of 8), stop deferred to addr 7
    runBurst(2, 20, 1, -1, "R3", e);
    chk("R3", "end index", e, 5);
    // R3: pressure on a line-final dword stops there
    lineSizeDw = 16;
    runBurst(10, 20, 5, -1, "R3", e);
    chk("R3", "end index", e, 5);

    // R4: inactive -> immediate stop
    alignEn = 0; lineSizeDw = 8;
    runBurst(1, 20, 2, -1, "R4", e);
    chk("R4", "end index", e, 2);

    // R2: unsupported size with enable set behaves as inactive
    alignEn = 1; lineSizeDw = 12;
    runBurst(1, 20, 3, -1, "R2", e);
    chk("R2", "end index", e, 3);
    ctrlRead = 1; reqAddr = 32'h2B;
    idle("R2");
    ctrlRead = 0;

    // R7: limit 16 bytes reached on 4th dword, switch held to line end (31)
    lineSizeDw = 16; arbEn = 1; arbLimit = 16;
    runBurst(19, 20, -1, 0, "R7", e);
    chk("R7", "end index", e, 12);
    // R7: counter disabled -> no switch, natural end
    arbEn = 0;
    runBurst(19, 20, -1, 0, "R7", e);
    chk("R7", "end index", e, 19);

    // R6: saturation, pending rises later, stop at next line end
    arbEn = 1; arbLimit = 8; lineSizeDw = 8;
    runBurst(0, 20, -1, 6, "R6", e);
    chk("R6", "end index", e, 7);
    // R6: restart at burst start: limit 12 -> 3 dwords needed again
    arbLimit = 12; alignEn = 0;
    runBurst(8, 2, -1, -1, "R6", e);
    runBurst(8, 20, -1, 0, "R6", e);
    chk("R6", "end index", e, 2);

    // R8: inactive, switch as soon as limit reached
    arbLimit = 20;
    runBurst(3, 20, -1, 0, "R8", e);
    chk("R8", "end index", e, 4);
    arbEn = 0;

    // R9 / R1: start address alignment for control reads
    alignEn = 1; lineSizeDw = 8; ctrlRead = 1;
    reqAddr = 32'h1D; idle("R9");
    lineSizeDw = 16; reqAddr = 32'h1D; idle("R9");
    reqAddr = 32'h40; idle("R9");
    ctrlRead = 0; reqAddr = 32'h1D; idle("R1");
    alignEn = 0; ctrlRead = 1; idle("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule